// File: doc/BRIEF.md
# Atomic Memory Word Exchange Sequencer

This block is a multi-cycle controller that executes one instruction: exchanging two words in memory as a single sequence that nothing else can split. When the core presents an instruction word, the sequencer decodes it as a register-format instruction. It reads three register operands through its register-read ports: two offsets and a shared base. It adds each offset to the base to form two effective addresses, and then issues four accesses to a single-port memory. First it reads both locations. Then it writes each location with the value that was read from the other.

The memory side uses a request/ready handshake. A lock output stays high for the whole run of accesses, so that an external arbiter can keep other masters away until the exchange is complete. The core side uses an instruction-valid input and a one-cycle done pulse. An error flag reports an instruction word that does not encode the exchange, and an effective address that is not aligned to a word. In both error cases the memory is left untouched.

Top module: `memswap_seq`

## Requirements
- R1: A word with opcode bits [31:26]=0, shift-amount bits [10:6]=0 and function bits [5:0]=0x2C is accepted as the exchange when the block is idle. Bits [25:21] name the first offset register, bits [20:16] the second offset register and bits [15:11] the base register. Any other word ends with a done pulse and err=1, and no memory request is made.
- R2: The first address is first offset + base and the second address is second offset + base. Both sums are 32-bit and wrap modulo 2^32.
- R3: The accesses come in a fixed order: read first address, read second address, write first address, write second address.
- R4: When the run completes, each location holds the other's former word. When both addresses are equal, the memory ends unchanged.
- R5: If either address has a nonzero value in bits [1:0], done is given with err=1 and no memory access is made.
- R6: mem_lock is high in every cycle in which mem_req is high. It rises at the first read and falls only once the final write is acknowledged.
- R7: A request keeps mem_req, mem_addr, mem_we and mem_wdata steady until mem_ready is seen, and the sequence moves on only on a cycle with mem_ready.
- R8: done is high for exactly one cycle, the cycle after the final write is acknowledged. err is valid in that cycle.
- R9: instr_valid is ignored while busy is high.
- R10: After reset, busy, done, err, mem_req and mem_lock are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Register-format instruction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal encoding or misaligned address |
| rf_raddr_a | output | 5 | First offset register index |
| rf_raddr_b | output | 5 | Second offset register index |
| rf_raddr_c | output | 5 | Base register index |
| rf_rdata_a | input | 32 | First offset value |
| rf_rdata_b | input | 32 | Second offset value |
| rf_rdata_c | input | 32 | Base value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_lock | output | 1 | Hold other masters off |

## Verification
The exchange is tried with distinct addresses and a memory that answers at once. This shows the access order and that the two words cross over. It is then tried with three wait cycles per access, which separates advancing on ready from advancing on request. Equal addresses show that the order of the writes leaves the memory intact. A base near 2^32 with offsets that wrap separates modular addition from saturating addition or a wider sum. Misaligned offsets, a wrong function code, a nonzero shift amount and a second instruction-valid issued in the middle of a run show that none of these reaches the memory.

// File: rtl/memswap_pkg.sv
package memswap_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;

  typedef struct packed {
    logic [5:0] op;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [4:0] shamt;
    logic [5:0] funct;
  } rfmt_t;

  typedef enum logic [2:0] {
    S_IDLE, S_OPER, S_RD_A, S_RD_B, S_WR_A, S_WR_B, S_DONE
  } seq_state_t;
endpackage

// File: rtl/memswap_decode.sv
module memswap_decode
  import memswap_pkg::*;
#(
  parameter logic [5:0] SWAP_FUNCT = 6'h2C
) (
  input  logic [INSTR_W-1:0]   instr,
  output logic                 is_swap,
  output logic [REG_IDX_W-1:0] off_a_idx,
  output logic [REG_IDX_W-1:0] off_b_idx,
  output logic [REG_IDX_W-1:0] base_idx
);
  rfmt_t f;
  always_comb begin
    f         = rfmt_t'(instr);
    is_swap   = (f.op == 6'd0) && (f.shamt == 5'd0) && (f.funct == SWAP_FUNCT);
    off_a_idx = f.rs;
    off_b_idx = f.rt;
    base_idx  = f.rd;
  end
endmodule

// File: rtl/memswap_agen.sv
module memswap_agen #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic              misaligned
);
  always_comb begin
    addr       = offset + base;
    misaligned = |addr[ALIGN_BITS-1:0];
  end
endmodule

// File: rtl/memswap_seq.sv
module memswap_seq
  import memswap_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter int         DATA_W     = 32,
  parameter logic [5:0] SWAP_FUNCT = 6'h2C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instr_valid,
  input  logic [INSTR_W-1:0]   instr_word,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [REG_IDX_W-1:0] rf_raddr_a,
  output logic [REG_IDX_W-1:0] rf_raddr_b,
  output logic [REG_IDX_W-1:0] rf_raddr_c,
  input  logic [ADDR_W-1:0]    rf_rdata_a,
  input  logic [ADDR_W-1:0]    rf_rdata_b,
  input  logic [ADDR_W-1:0]    rf_rdata_c,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_ready,
  output logic                 mem_lock
);
  localparam int ALIGN_BITS = $clog2(DATA_W / 8);
  localparam int NUM_ADDR   = 2;

  seq_state_t state;
  logic [REG_IDX_W-1:0] idx_a, idx_b, idx_c;
  logic [REG_IDX_W-1:0] dec_a, dec_b, dec_c;
  logic                 dec_ok;
  logic [ADDR_W-1:0]    addr_q   [NUM_ADDR];
  logic [ADDR_W-1:0]    addr_nx  [NUM_ADDR];
  logic [ADDR_W-1:0]    off_v    [NUM_ADDR];
  logic [NUM_ADDR-1:0]  mis_v;
  logic [DATA_W-1:0]    tmp_a, tmp_b;
  logic                 err_q, lock_q;

  memswap_decode #(.SWAP_FUNCT(SWAP_FUNCT)) u_dec (
    .instr(instr_word), .is_swap(dec_ok),
    .off_a_idx(dec_a), .off_b_idx(dec_b), .base_idx(dec_c)
  );

  assign off_v[0] = rf_rdata_a;
  assign off_v[1] = rf_rdata_b;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_agen
    memswap_agen #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_agen (
      .offset(off_v[g]), .base(rf_rdata_c),
      .addr(addr_nx[g]), .misaligned(mis_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      idx_a  <= '0;
      idx_b  <= '0;
      idx_c  <= '0;
      tmp_a  <= '0;
      tmp_b  <= '0;
      err_q  <= 1'b0;
      lock_q <= 1'b0;
      for (int i = 0; i < NUM_ADDR; i++) addr_q[i] <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (instr_valid) begin
          err_q <= 1'b0;
          idx_a <= dec_a;
          idx_b <= dec_b;
          idx_c <= dec_c;
          if (dec_ok) state <= S_OPER;
          else begin
            err_q <= 1'b1;
            state <= S_DONE;
          end
        end
        S_OPER: begin
          for (int i = 0; i < NUM_ADDR; i++) addr_q[i] <= addr_nx[i];
          if (|mis_v) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else begin
            lock_q <= 1'b1;
            state  <= S_RD_A;
          end
        end
        S_RD_A: if (mem_ready) begin
          tmp_a <= mem_rdata;
          state <= S_RD_B;
        end
        S_RD_B: if (mem_ready) begin
          tmp_b <= mem_rdata;
          state <= S_WR_A;
        end
        S_WR_A: if (mem_ready) state <= S_WR_B;
        S_WR_B: if (mem_ready) begin
          lock_q <= 1'b0;
          state  <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state != S_IDLE);
    done       = (state == S_DONE);
    err        = err_q;
    rf_raddr_a = idx_a;
    rf_raddr_b = idx_b;
    rf_raddr_c = idx_c;
    mem_req    = (state == S_RD_A) || (state == S_RD_B) ||
                 (state == S_WR_A) || (state == S_WR_B);
    mem_we     = (state == S_WR_A) || (state == S_WR_B);
    mem_addr   = ((state == S_RD_A) || (state == S_WR_A)) ? addr_q[0] : addr_q[1];
    mem_wdata  = (state == S_WR_A) ? tmp_b : tmp_a;
    mem_lock   = lock_q;
  end
endmodule

// File: rtl/memswap_sva.sv
module memswap_sva #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              mem_lock
);
  assert_lock_covers_req_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_lock);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_lock_release_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_lock);

  assert_write_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[ALIGN_BITS-1:0] == '0));

  assert_req_only_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_req && !mem_lock));
endmodule

bind memswap_seq memswap_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)
) u_sva (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .mem_lock(mem_lock)
);

// File: tb/tb_memswap_seq.sv
module tb_memswap_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        busy, done, err;
  logic [4:0]  rf_raddr_a, rf_raddr_b, rf_raddr_c;
  logic [31:0] rf_rdata_a, rf_rdata_b, rf_rdata_c;
  logic        mem_req, mem_we, mem_ready, mem_lock;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  memswap_seq dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .busy(busy), .done(done), .err(err),
    .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b), .rf_raddr_c(rf_raddr_c),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b), .rf_rdata_c(rf_rdata_c),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_lock(mem_lock)
  );

  logic [31:0] regs [32];
  logic [31:0] mem  [64];
  logic [31:0] log_addr [8];
  logic        log_we   [8];
  int log_n = 0, wait_cycles = 0, wcnt = 0;
  int negcnt = 0, req_cycles = 0, lock_bad = 0, last_wr_neg = -10, done_neg = -10;
  int tests = 0, fails = 0;

  assign rf_rdata_a = regs[rf_raddr_a];
  assign rf_rdata_b = regs[rf_raddr_b];
  assign rf_rdata_c = regs[rf_raddr_c];
  assign mem_ready  = mem_req && (wcnt >= wait_cycles);
  assign mem_rdata  = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      wcnt = 0;
      if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
      if (log_n < 8) begin
        log_addr[log_n] = mem_addr;
        log_we[log_n]   = mem_we;
      end
      log_n = log_n + 1;
    end else if (mem_req) wcnt = wcnt + 1;
  end

  always @(negedge clk) begin
    if (mem_req) req_cycles = req_cycles + 1;
    if (mem_req && !mem_lock) lock_bad = lock_bad + 1;
    if (mem_req && mem_ready && mem_we) last_wr_neg = negcnt;
    if (done) done_neg = negcnt;
    negcnt = negcnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                                      input logic [4:0] sh, input logic [5:0] fn);
    return {6'd0, a, b, c, sh, fn};
  endfunction

  task automatic clear_stats();
    log_n = 0; req_cycles = 0; lock_bad = 0; last_wr_neg = -10; done_neg = -10;
  endtask

  task automatic run(input logic [31:0] iw, output logic e_out);
    int guard;
    @(negedge clk); #1;
    instr_valid = 1'b1; instr_word = iw;
    @(negedge clk); #1;
    instr_valid = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk); #1;
      guard++;
    end
    check(done == 1'b1, "R8 done seen", {31'd0, done}, 32'd1);
    e_out = err;
    @(negedge clk); #1;
    check(done == 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    check({busy, done, err, mem_req, mem_lock} == 5'b0, "R10 reset outputs",
          {27'd0, busy, done, err, mem_req, mem_lock}, 32'd0);
  endtask

  task automatic t_basic(input int w, input string tag);
    logic e;
    wait_cycles = w;
    regs[1] = 32'h8; regs[2] = 32'h20; regs[3] = 32'h40;
    mem[18] = 32'hAAAA_0001; mem[24] = 32'hBBBB_0002;
    clear_stats();
    run(enc(5'd1, 5'd2, 5'd3, 5'd0, 6'h2C), e);
    check(e == 1'b0, {tag, " R1 accepted"}, {31'd0, e}, 32'd0);
    check(log_n == 4, {tag, " R3 four accesses"}, log_n, 4);
    check(log_addr[0] == 32'h48 && !log_we[0], {tag, " R2 R3 read A"}, log_addr[0], 32'h48);
    check(log_addr[1] == 32'h60 && !log_we[1], {tag, " R2 R3 read B"}, log_addr[1], 32'h60);
    check(log_addr[2] == 32'h48 && log_we[2], {tag, " R3 write A"}, log_addr[2], 32'h48);
    check(log_addr[3] == 32'h60 && log_we[3], {tag, " R3 write B"}, log_addr[3], 32'h60);
    check(mem[18] == 32'hBBBB_0002, {tag, " R4 A holds B"}, mem[18], 32'hBBBB_0002);
    check(mem[24] == 32'hAAAA_0001, {tag, " R4 B holds A"}, mem[24], 32'hAAAA_0001);
    check(done_neg == last_wr_neg + 1, {tag, " R8 done after last ack"}, done_neg, last_wr_neg + 1);
    check(lock_bad == 0, {tag, " R6 lock with req"}, lock_bad, 0);
    check(req_cycles == 4 * (w + 1), {tag, " R7 req held until ready"}, req_cycles, 4 * (w + 1));
  endtask

  task automatic t_same();
    logic e;
    wait_cycles = 1;
    regs[4] = 32'h10; regs[5] = 32'h10; regs[6] = 32'h20;
    mem[12] = 32'hCAFE_F00D;
    clear_stats();
    run(enc(5'd4, 5'd5, 5'd6, 5'd0, 6'h2C), e);
    check(e == 1'b0 && log_n == 4, "R4 equal addr runs", log_n, 4);
    check(mem[12] == 32'hCAFE_F00D, "R4 equal addr unchanged", mem[12], 32'hCAFE_F00D);
  endtask

  task automatic t_wrap();
    logic e;
    wait_cycles = 0;
    regs[7] = 32'h20; regs[8] = 32'h14; regs[9] = 32'hFFFF_FFF0;
    mem[4] = 32'h1111_1111; mem[1] = 32'h2222_2222;
    clear_stats();
    run(enc(5'd7, 5'd8, 5'd9, 5'd0, 6'h2C), e);
    check(log_addr[0] == 32'h10, "R2 wrap first", log_addr[0], 32'h10);
    check(log_addr[1] == 32'h04, "R2 wrap second", log_addr[1], 32'h04);
    check(mem[4] == 32'h2222_2222 && mem[1] == 32'h1111_1111, "R4 wrap swap", mem[4], 32'h2222_2222);
  endtask

  task automatic t_misaligned();
    logic e;
    regs[10] = 32'h2; regs[11] = 32'h8; regs[12] = 32'h0;
    mem[0] = 32'h5A5A_0000; mem[2] = 32'hA5A5_0000;
    clear_stats();
    run(enc(5'd10, 5'd11, 5'd12, 5'd0, 6'h2C), e);
    check(e == 1'b1, "R5 err on misaligned", {31'd0, e}, 32'd1);
    check(req_cycles == 0, "R5 no access", req_cycles, 0);
    check(mem[2] == 32'hA5A5_0000 && mem[0] == 32'h5A5A_0000, "R5 memory kept", mem[2], 32'hA5A5_0000);
  endtask

  task automatic t_illegal();
    logic e;
    clear_stats();
    run(enc(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), e);
    check(e == 1'b1 && req_cycles == 0, "R1 wrong funct", {31'd0, e}, 32'd1);
    clear_stats();
    run(enc(5'd1, 5'd2, 5'd3, 5'd4, 6'h2C), e);
    check(e == 1'b1 && req_cycles == 0, "R1 nonzero shamt", {31'd0, e}, 32'd1);
    clear_stats();
    run({6'd4, 5'd1, 5'd2, 5'd3, 5'd0, 6'h2C}, e);
    check(e == 1'b1 && req_cycles == 0, "R1 nonzero opcode", {31'd0, e}, 32'd1);
  endtask

  task automatic t_busy();
    logic e;
    int guard;
    wait_cycles = 2;
    regs[13] = 32'h80; regs[14] = 32'h84; regs[15] = 32'h0;
    regs[16] = 32'hC0; regs[17] = 32'hC4;
    mem[32] = 32'h0000_00AA; mem[33] = 32'h0000_00BB;
    mem[48] = 32'h0000_00CC; mem[49] = 32'h0000_00DD;
    clear_stats();
    @(negedge clk); #1;
    instr_valid = 1'b1; instr_word = enc(5'd13, 5'd14, 5'd15, 5'd0, 6'h2C);
    @(negedge clk); #1;
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    instr_valid = 1'b1; instr_word = enc(5'd16, 5'd17, 5'd15, 5'd0, 6'h2C);
    @(negedge clk); #1;
    instr_valid = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk); #1;
      guard++;
    end
    e = err;
    repeat (12) @(negedge clk);
    #1;
    check(e == 1'b0 && log_n == 4, "R9 one sequence only", log_n, 4);
    check(mem[48] == 32'hCC && mem[49] == 32'hDD, "R9 second pair untouched", mem[48], 32'hCC);
    check(mem[32] == 32'hBB && mem[33] == 32'hAA, "R9 first pair swapped", mem[32], 32'hBB);
    check(busy == 1'b0, "R9 idle afterwards", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_basic(0, "fast");
    t_basic(3, "slow");
    t_same();
    t_wrap();
    t_misaligned();
    t_illegal();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule